// File: doc/BRIEF.md
# Interrupt Enable and Threshold Gating Unit

This block produces the single host interrupt line of a USB 2.0 host controller's register file. Six event sources (USB transaction done, USB error, port change, frame list rollover, host system error and async-schedule advance) arrive as one-cycle pulses. Each pulse latches a bit in a status register. A matching bit in an enable register decides whether that latched bit may drive the interrupt line. Disabled sources still latch, so software can poll the status register instead.

Three sources are urgent: host system error, frame list rollover and port change assert the line as soon as status and enable are both set. The other three are deferred. Async-advance, USB error and USB transaction done wait for the next interrupt-threshold boundary, which is derived from a microframe tick input. A small sequencer with two states counts ticks. In `TM_COUNT` it counts microframe ticks. When the programmed number of ticks has been seen, it moves to `TM_FIRE`, which marks one boundary. From `TM_FIRE`, a tick that completes another interval keeps it in `TM_FIRE`; otherwise it returns to `TM_COUNT`. `TM_COUNT` stays put until an interval completes. At a boundary, each deferred source that is pending and enabled sets a release flag. That flag lets the source drive the line until its status bit is acknowledged.

Software reaches three registers through a single-cycle port with registered read data: interval code at offset 0x20, status at offset 0x24 and enable at offset 0x28.

Top module: `irq_gate_unit`

## Requirements
- R1: After reset the enable register reads 0, the status register reads 0, the interval code reads 3 and `irq_o` is 0.
- R2: The enable register at offset 0x28 keeps write-data bits 5:0. Bits 31:6 of every read are always 0.
- R3: An event pulse on `evt_i[k]` sets status bit k whatever enable bit k holds. A source whose enable bit is 0 never drives `irq_o`.
- R4: Status and enable bits use the same positions: 5 async-advance, 4 host system error, 3 frame list rollover, 2 port change, 1 USB error, 0 USB transaction done. Bits 4, 3 and 2 are immediate. `irq_o` is 1 in the cycle after the clock edge at which both their status and enable bits are 1.
- R5: Bits 5, 1 and 0 are deferred. While pending and enabled they keep `irq_o` low until a threshold boundary has passed. They assert it one cycle after the boundary state.
- R6: The status register at offset 0x24 is write-1-to-clear. A 0 written to a bit leaves it unchanged. An event pulse in the same cycle as a clear of the same bit leaves the bit set.
- R7: `irq_o` falls once no bit is both set in status and enabled, whether through a status clear or an enable clear.
- R8: Bits 2:0 at offset 0x20 hold an interval code c. The interval is 2^c microframe ticks. Written values above 6 are stored as 6. A boundary follows the tick that completes the interval.
- R9: Setting an enable bit while its status bit is already 1 asserts `irq_o` on the next cycle for an immediate source. For a deferred source it asserts only after the next boundary.
- R10: Reads of any other offset return 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data for the offset sampled at the previous edge |
| evt_i | input | 6 | One-cycle event pulses, one per source |
| uframe_tick_i | input | 1 | One-cycle microframe tick |
| irq_o | output | 1 | Host interrupt line |

## Verification
The assertions assume that the microframe tick and the event pulses are synchronous to the clock and that inputs are stable around each rising edge. They also assume that the sequencer's boundary state can only be entered on a cycle after a tick. The stimulus drives every input on the falling edge and raises ticks only as single-cycle pulses. It also starts each deferred-source scenario with the tick count at zero, so the boundary cycle is known in advance. Offsets are always one of the three defined ones, except in the case that probes an undefined offset.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    localparam int SRC_N     = 6;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int CODE_W    = 3;
    localparam int CODE_MAX  = 6;
    localparam int CODE_RST  = 3;
    localparam logic [ADDR_W-1:0] OFF_CODE = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_STS  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_EN   = 8'h28;
    // deferred sources: async-advance (5), USB error (1), transaction done (0)
    localparam logic [SRC_N-1:0] DEFER_MASK = 6'b100011;

    typedef enum logic [0:0] {
        TM_COUNT = 1'b0,
        TM_FIRE  = 1'b1
    } tm_state_e;
endpackage

// File: rtl/irq_thresh_fsm.sv
module irq_thresh_fsm
    import irq_gate_pkg::*;
#(
    parameter int CW   = CODE_W,
    parameter int CMAX = CODE_MAX
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic [CW-1:0] code_i,
    output logic          boundary_o
);
    localparam int CNT_W = CMAX + 1;

    tm_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_w;
    logic             wrap_w;

    assign last_w = (CNT_W'(1) << code_i) - CNT_W'(1);
    assign wrap_w = tick_i && (cnt_q >= last_w);

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (tick_i) begin
            cnt_d = wrap_w ? '0 : cnt_q + CNT_W'(1);
        end
        unique case (st_q)
            TM_COUNT: st_d = wrap_w ? TM_FIRE : TM_COUNT;
            TM_FIRE:  st_d = wrap_w ? TM_FIRE : TM_COUNT;
            default:  st_d = TM_COUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= TM_COUNT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            TM_FIRE:  boundary_o = 1'b1;
            default:  boundary_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_gate_pkg::*;
#(
    parameter int              N     = SRC_N,
    parameter logic [N-1:0]    DEFER = DEFER_MASK
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    input  logic         en_wr_i,
    input  logic [N-1:0] en_data_i,
    input  logic         boundary_i,
    output logic [N-1:0] sts_o,
    output logic [N-1:0] en_o,
    output logic [N-1:0] rel_o,
    output logic         irq_o
);
    logic [N-1:0] sts_q, en_q, rel_q;
    logic [N-1:0] sts_d, en_d, rel_d;
    logic [N-1:0] live_w;

    assign sts_d = (sts_q & ~clr_i) | evt_i;
    assign en_d  = en_wr_i ? en_data_i : en_q;
    assign rel_d = (rel_q | ({N{boundary_i}} & sts_q & en_q & DEFER)) & sts_d & en_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sts_q <= '0;
            en_q  <= '0;
            rel_q <= '0;
        end else begin
            sts_q <= sts_d;
            en_q  <= en_d;
            rel_q <= rel_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        if (DEFER[i]) begin : g_defer
            assign live_w[i] = rel_q[i] & sts_q[i] & en_q[i];
        end else begin : g_imm
            assign live_w[i] = sts_q[i] & en_q[i];
        end
    end

    assign irq_o = |live_w;
    assign sts_o = sts_q;
    assign en_o  = en_q;
    assign rel_o = rel_q;
endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port
    import irq_gate_pkg::*;
#(
    parameter int N    = SRC_N,
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int CW   = CODE_W,
    parameter int CMAX = CODE_MAX,
    parameter int CRST = CODE_RST
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [N-1:0]  sts_i,
    input  logic [N-1:0]  en_i,
    output logic [N-1:0]  clr_o,
    output logic          en_wr_o,
    output logic [N-1:0]  en_data_o,
    output logic [CW-1:0] code_o,
    output logic [DW-1:0] rd_data_o
);
    logic [CW-1:0] code_q, code_w;
    logic [DW-1:0] rd_q, rd_d;
    logic          unused_hi;

    assign unused_hi = ^wr_data_i[DW-1:N];
    assign code_w    = (wr_data_i[CW-1:0] > CW'(CMAX)) ? CW'(CMAX) : wr_data_i[CW-1:0];
    assign clr_o     = (wr_en_i && addr_i == OFF_STS) ? wr_data_i[N-1:0] : '0;
    assign en_wr_o   = wr_en_i && (addr_i == OFF_EN);
    assign en_data_o = wr_data_i[N-1:0];

    always_comb begin
        unique case (addr_i)
            OFF_CODE: rd_d = DW'(code_q);
            OFF_STS:  rd_d = DW'(sts_i);
            OFF_EN:   rd_d = DW'(en_i);
            default:  rd_d = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            code_q <= CW'(CRST);
            rd_q   <= '0;
        end else begin
            if (wr_en_i && addr_i == OFF_CODE) code_q <= code_w;
            rd_q <= rd_d;
        end
    end

    assign code_o    = code_q;
    assign rd_data_o = rd_q;
endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit
    import irq_gate_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [SRC_N-1:0]  evt_i,
    input  logic              uframe_tick_i,
    output logic              irq_o
);
    logic [SRC_N-1:0]  sts_w, en_w, rel_w, clr_w, en_dat_w;
    logic              en_wr_w, bnd_w;
    logic [CODE_W-1:0] code_w;

    irq_csr_port u_csr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .sts_i     (sts_w),
        .en_i      (en_w),
        .clr_o     (clr_w),
        .en_wr_o   (en_wr_w),
        .en_data_o (en_dat_w),
        .code_o    (code_w),
        .rd_data_o (rd_data_o)
    );

    irq_thresh_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (uframe_tick_i),
        .code_i     (code_w),
        .boundary_o (bnd_w)
    );

    irq_src_bank u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (evt_i),
        .clr_i      (clr_w),
        .en_wr_i    (en_wr_w),
        .en_data_i  (en_dat_w),
        .boundary_i (bnd_w),
        .sts_o      (sts_w),
        .en_o       (en_w),
        .rel_o      (rel_w),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk
    import irq_gate_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [SRC_N-1:0]  evt_i,
    input logic              uframe_tick_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              irq_o,
    input logic [SRC_N-1:0]  sts_w,
    input logic [SRC_N-1:0]  en_w,
    input logic [SRC_N-1:0]  rel_w,
    input logic              bnd_w
);
    localparam logic [SRC_N-1:0] IMM = ~DEFER_MASK;

    p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[DATA_W-1:SRC_N] == '0);

    p_evt_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((sts_w & $past(evt_i)) == $past(evt_i)));

    p_imm_fast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sts_w & en_w & IMM) != '0) |-> irq_o);

    p_defer_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rel_w & ~$past(rel_w)) != '0) |-> $past(bnd_w));

    p_irq_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((sts_w & en_w) != '0));

    p_bnd_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bnd_w |-> $past(uframe_tick_i));
endmodule

bind irq_gate_unit irq_gate_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .evt_i         (evt_i),
    .uframe_tick_i (uframe_tick_i),
    .rd_data_o     (rd_data_o),
    .irq_o         (irq_o),
    .sts_w         (sts_w),
    .en_w          (en_w),
    .rel_w         (rel_w),
    .bnd_w         (bnd_w)
);

// File: tb/irq_gate_unit_tb_top.sv
`timescale 1ns/1ps
module irq_gate_unit_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  addr_i = 8'h0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic [5:0]  evt_i = '0;
    logic        uframe_tick_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    irq_gate_unit dut_i (.*);

    // {enable, event, expected status, expected irq before any boundary}
    localparam logic [18:0] VEC [8] = '{
        {6'h3F, 6'h04, 6'h04, 1'b1},
        {6'h3F, 6'h08, 6'h08, 1'b1},
        {6'h3F, 6'h10, 6'h10, 1'b1},
        {6'h3F, 6'h01, 6'h01, 1'b0},
        {6'h3F, 6'h20, 6'h20, 1'b0},
        {6'h00, 6'h3F, 6'h3F, 1'b0},
        {6'h1C, 6'h23, 6'h23, 1'b0},
        {6'h04, 6'h08, 6'h08, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk_i);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk_i);
        addr_i = a;
        @(negedge clk_i);
        d = rd_data_o;
    endtask

    task automatic pulse(input logic [5:0] e);
        @(negedge clk_i);
        evt_i = e;
        @(negedge clk_i);
        evt_i = '0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk_i);
            uframe_tick_i = 1'b1;
            @(negedge clk_i);
            uframe_tick_i = 1'b0;
        end
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        rd(8'h28, r); chk("R1 enable", r, 32'h0);
        rd(8'h24, r); chk("R1 status", r, 32'h0);
        rd(8'h20, r); chk("R1 code", r, 32'h3);

        // R3 R4 R5 vector table, no ticks so no boundary occurs
        for (int v = 0; v < 8; v++) begin
            wr(8'h28, {26'b0, VEC[v][18:13]});
            pulse(VEC[v][12:7]);
            chk($sformatf("R4/R5/R3 vec%0d irq", v), {31'b0, irq_o}, {31'b0, VEC[v][0]});
            rd(8'h24, r);
            chk($sformatf("R3 vec%0d status", v), r, {26'b0, VEC[v][6:1]});
            wr(8'h24, 32'h3F);
            chk($sformatf("R7 vec%0d irq after clear", v), {31'b0, irq_o}, 32'h0);
        end

        // R5 deferred source waits for boundary of 8 ticks
        wr(8'h28, 32'h01);
        pulse(6'h01);
        ticks(7);
        chk("R5 before boundary", {31'b0, irq_o}, 32'h0);
        ticks(1);
        chk("R5 boundary cycle", {31'b0, irq_o}, 32'h0);
        @(negedge clk_i);
        chk("R5 after boundary", {31'b0, irq_o}, 32'h1);
        wr(8'h24, 32'h01);
        chk("R7 ack deferred", {31'b0, irq_o}, 32'h0);

        // R9 immediate source enabled late
        wr(8'h28, 32'h0);
        pulse(6'h04);
        chk("R3 disabled no irq", {31'b0, irq_o}, 32'h0);
        wr(8'h28, 32'h04);
        chk("R9 immediate late enable", {31'b0, irq_o}, 32'h1);
        wr(8'h24, 32'h04);

        // R9 deferred source enabled late
        wr(8'h28, 32'h0);
        pulse(6'h20);
        wr(8'h28, 32'h20);
        chk("R9 deferred late enable waits", {31'b0, irq_o}, 32'h0);
        ticks(8);
        @(negedge clk_i);
        chk("R9 deferred after boundary", {31'b0, irq_o}, 32'h1);
        wr(8'h24, 32'h20);

        // R8 interval code 1 -> 2 ticks
        wr(8'h20, 32'h1);
        rd(8'h20, r); chk("R8 code readback", r, 32'h1);
        wr(8'h28, 32'h01);
        pulse(6'h01);
        ticks(1);
        chk("R8 one tick of two", {31'b0, irq_o}, 32'h0);
        ticks(1);
        @(negedge clk_i);
        chk("R8 two ticks boundary", {31'b0, irq_o}, 32'h1);
        wr(8'h24, 32'h01);

        // R8 clamp to 6 -> 64 ticks
        wr(8'h20, 32'h7);
        rd(8'h20, r); chk("R8 clamp", r, 32'h6);
        wr(8'h28, 32'h02);
        pulse(6'h02);
        ticks(63);
        chk("R8 63 of 64 ticks", {31'b0, irq_o}, 32'h0);
        ticks(1);
        @(negedge clk_i);
        chk("R8 64 ticks boundary", {31'b0, irq_o}, 32'h1);
        wr(8'h24, 32'h02);

        // R6 write-1-to-clear details
        wr(8'h28, 32'h0);
        pulse(6'h08);
        wr(8'h24, 32'h0);
        rd(8'h24, r); chk("R6 zero write keeps", r, 32'h08);
        wr(8'h24, 32'h08);
        rd(8'h24, r); chk("R6 one write clears", r, 32'h0);
        @(negedge clk_i);
        addr_i = 8'h24; wr_data_i = 32'h08; wr_en_i = 1'b1; evt_i = 6'h08;
        @(negedge clk_i);
        wr_en_i = 1'b0; evt_i = '0;
        rd(8'h24, r); chk("R6 event beats clear", r, 32'h08);
        wr(8'h24, 32'h3F);

        // R7 deassert via enable and via status
        wr(8'h28, 32'h10);
        pulse(6'h10);
        chk("R7 set", {31'b0, irq_o}, 32'h1);
        wr(8'h28, 32'h0);
        chk("R7 enable cleared", {31'b0, irq_o}, 32'h0);
        wr(8'h28, 32'h10);
        chk("R7 re-enabled", {31'b0, irq_o}, 32'h1);
        wr(8'h24, 32'h10);
        chk("R7 status cleared", {31'b0, irq_o}, 32'h0);

        // R2 reserved enable bits
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, r); chk("R2 enable reserved zero", r, 32'h3F);
        wr(8'h28, 32'h0);

        // R10 undefined offset
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, r); chk("R10 undefined read", r, 32'h0);
        rd(8'h28, r); chk("R10 enable untouched", r, 32'h0);
        rd(8'h20, r); chk("R10 code untouched", r, 32'h6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule